// File: doc/BRIEF.md
# Waveform Trace Raster Overlay

This block turns a buffer of signed samples into an oscilloscope-style trace on an 800 by 600 raster. It generates the horizontal and vertical timing itself. With the default porch and sync widths and a 40 MHz pixel clock, the frame rate is about 60.3 Hz. Inside a plot rectangle one sample column is read per pixel column. The rectangle is 512 columns wide by default and is as tall as the vertical window has levels. A small group of bits is cut from each wide sample word at a runtime bit offset. The pixel whose row matches that value is lit. A horizontal axis line marks the zero level, and every other pixel is background.

Vertical scaling needs no multiplier. Raising the bit offset divides the trace by two for each step, and lowering it zooms in. The sample buffer sits outside the block and is reached through a synchronous read port. The port has a fixed latency of one clock and no back-pressure: the block raises a read strobe with an address, and the word must be present on the data input at the next clock edge. Sync, data-enable and pixel code leave the block together, two clocks after the raster position they describe.

Top module: `wave_trace_viewer`

## Requirements
- R1: The horizontal counter runs over H_ACT+H_FP+H_SYNC+H_BP positions per line. `hsync` is high exactly for positions H_ACT+H_FP through H_ACT+H_FP+H_SYNC-1.
- R2: The line counter advances once per line and wraps after V_ACT+V_FP+V_SYNC+V_BP lines. `vsync` is high exactly for lines V_ACT+V_FP through V_ACT+V_FP+V_SYNC-1.
- R3: `de` is high only for positions below H_ACT and lines below V_ACT. Whenever `de` is low, `pix` is 2'b00.
- R4: `rd_en` is high in exactly those cycles in which the counters lie inside the plot rectangle. Column PLOT_LEFT+k issues address k, and the rectangle starts at line PLOT_TOP and is 2^SLICE_W lines tall. The returned word is used one clock later.
- R5: The plotted value is bits bit_offset+SLICE_W-1 down to bit_offset of the sample, read as a signed SLICE_W-bit number. Bit positions above the sample MSB read as the sign bit.
- R6: With HALF = 2^(SLICE_W-1), the trace pixel (code 2'b10) of plot column k is lit on plot row HALF-1-w, where w is the value from R5. Every column holds exactly one trace pixel, so a constant buffer draws a flat line.
- R7: Plot row HALF-1 (value zero) shows the axis code 2'b01 where no trace lies. Where trace and axis fall on the same pixel, the trace code 2'b10 wins.
- R8: Pixels inside the active area but outside the plot rectangle show background 2'b00.
- R9: During reset `hsync`, `vsync`, `de`, `pix` and `rd_en` are low. Counting restarts at position 0 of line 0.
- R10: `hsync`, `vsync`, `de` and `pix` describe the raster position the counters held two clocks earlier. The first position after reset appears on the second clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_offset | input | $clog2(SAMPLE_W) | Lowest sample bit of the plotted window |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | $clog2(PLOT_W) | Sample index to read |
| rd_data | input | SAMPLE_W | Sample word, valid one clock after the strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active video |
| pix | output | 2 | Pixel code: 00 background, 01 axis, 10 trace |

## Verification
Trace drawing and axis drawing can land on the same pixel whenever the cut window of a sample equals zero. In that case the trace priority of R7 decides the code. The bench provokes this with an all-zero buffer and with ramps that cross zero. It also uses bit offsets at or above the sample width, where every window collapses to the sign and all-positive samples sit on the axis. A behavioural model checks every position against the expected code. It separately checks the rows one above and one below the axis, so a wrong priority or a row off by one is reported.

// File: rtl/wv_pkg.sv
package wv_pkg;

  typedef enum logic [1:0] {
    PIX_BG    = 2'b00,
    PIX_AXIS  = 2'b01,
    PIX_TRACE = 2'b10
  } pix_t;

  typedef struct packed {
    logic de;
    logic hsync;
    logic vsync;
  } tim_t;

endpackage

// File: rtl/wv_raster.sv
module wv_raster
  import wv_pkg::*;
#(
  parameter int H_ACT  = 800,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP   = 88,
  parameter int V_ACT  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP   = 23,
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output tim_t          tim
);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] HS_FROM = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_TO   = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_FROM = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_TO   = VW'(V_ACT + V_FP + V_SYNC);

  logic line_end;
  assign line_end = (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    tim.de    = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
    tim.hsync = (hcnt >= HS_FROM) && (hcnt < HS_TO);
    tim.vsync = (vcnt >= VS_FROM) && (vcnt < VS_TO);
  end

  // R1: the line wraps to position zero after its last position
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));

  // R2: the line counter only moves at a line end
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcnt));

endmodule

// File: rtl/wv_slice.sv
module wv_slice #(
  parameter int SAMPLE_W = 29,
  parameter int SLICE_W  = 9,
  localparam int OFS_W   = $clog2(SAMPLE_W),
  localparam int EXT_W   = SAMPLE_W + SLICE_W
) (
  input  logic [SAMPLE_W-1:0]       sample,
  input  logic [OFS_W-1:0]          offset,
  output logic signed [SLICE_W-1:0] win
);

  // sign-extend by a full window so any offset reads sign above the MSB
  logic signed [EXT_W-1:0] ext;
  assign ext = {{SLICE_W{sample[SAMPLE_W-1]}}, sample};
  assign win = SLICE_W'(ext >>> offset);

endmodule

// File: rtl/wv_pixel.sv
module wv_pixel
  import wv_pkg::*;
#(
  parameter int SLICE_W   = 9,
  parameter int PLOT_W    = 512,
  parameter int PLOT_LEFT = 144,
  parameter int PLOT_TOP  = 44,
  parameter int HW        = 11,
  parameter int VW        = 10,
  localparam int ADDR_W   = $clog2(PLOT_W),
  localparam int PLOT_H   = 2 ** SLICE_W,
  localparam int HALF     = PLOT_H / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HW-1:0]             hcnt,
  input  logic [VW-1:0]             vcnt,
  input  tim_t                      tim_in,
  output logic                      rd_en,
  output logic [ADDR_W-1:0]         rd_addr,
  input  logic signed [SLICE_W-1:0] win,
  output tim_t                      tim_out,
  output pix_t                      pix_out
);

  localparam logic [SLICE_W-1:0] AXIS_ROW = SLICE_W'(HALF - 1);

  logic in_x, in_y;
  logic [SLICE_W-1:0] row_now;

  assign in_x    = (hcnt >= HW'(PLOT_LEFT)) && (hcnt < HW'(PLOT_LEFT + PLOT_W));
  assign in_y    = (vcnt >= VW'(PLOT_TOP))  && (vcnt < VW'(PLOT_TOP + PLOT_H));
  assign rd_en   = in_x && in_y;
  assign rd_addr = ADDR_W'(hcnt - HW'(PLOT_LEFT));
  assign row_now = SLICE_W'(vcnt - VW'(PLOT_TOP));

  // stage 1: position waits while the buffer word is fetched
  tim_t               s1_tim;
  logic               s1_plot;
  logic [SLICE_W-1:0] s1_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_tim  <= '0;
      s1_plot <= 1'b0;
      s1_row  <= '0;
    end else begin
      s1_tim  <= tim_in;
      s1_plot <= rd_en;
      s1_row  <= row_now;
    end
  end

  // row that the window value lands on, kept in window arithmetic
  logic [SLICE_W-1:0] lit_row;
  pix_t               pix_next;

  assign lit_row = AXIS_ROW - $unsigned(win);

  always_comb begin
    pix_next = PIX_BG;
    if (s1_tim.de && s1_plot) begin
      if (s1_row == lit_row)       pix_next = PIX_TRACE;
      else if (s1_row == AXIS_ROW) pix_next = PIX_AXIS;
    end
  end

  // stage 2: registered outputs, sync kept in step with the pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim_out <= '0;
      pix_out <= PIX_BG;
    end else begin
      tim_out <= s1_tim;
      pix_out <= pix_next;
    end
  end

  // R3: nothing lit while video is inactive
  a_r3_dark_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !tim_out.de |-> (pix_out == PIX_BG));

  // R4: reads stay inside the buffer
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ({1'b0, rd_addr} < (ADDR_W + 1)'(PLOT_W)));

  // R4: consecutive reads on a line walk the buffer by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && (rd_addr != '0)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R7: the axis code appears only on the zero row
  a_r7_axis_row: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out == PIX_AXIS) |-> ($past(s1_row) == AXIS_ROW));

endmodule

// File: rtl/wave_trace_viewer.sv
module wave_trace_viewer
  import wv_pkg::*;
#(
  parameter int SAMPLE_W  = 29,
  parameter int SLICE_W   = 9,
  parameter int PLOT_W    = 512,
  parameter int PLOT_LEFT = 144,
  parameter int PLOT_TOP  = 44,
  parameter int H_ACT     = 800,
  parameter int H_FP      = 40,
  parameter int H_SYNC    = 128,
  parameter int H_BP      = 88,
  parameter int V_ACT     = 600,
  parameter int V_FP      = 1,
  parameter int V_SYNC    = 4,
  parameter int V_BP      = 23,
  localparam int OFS_W    = $clog2(SAMPLE_W),
  localparam int ADDR_W   = $clog2(PLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OFS_W-1:0]    bit_offset,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [SAMPLE_W-1:0] rd_data,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic [1:0]          pix
);

  localparam int HW = $clog2(H_ACT + H_FP + H_SYNC + H_BP);
  localparam int VW = $clog2(V_ACT + V_FP + V_SYNC + V_BP);

  logic [HW-1:0]             hcnt;
  logic [VW-1:0]             vcnt;
  tim_t                      tim_raw, tim_out;
  logic signed [SLICE_W-1:0] win;
  pix_t                      pix_code;

  wv_raster #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_raster (
    .clk  (clk),
    .rst_n(rst_n),
    .hcnt (hcnt),
    .vcnt (vcnt),
    .tim  (tim_raw)
  );

  wv_slice #(
    .SAMPLE_W(SAMPLE_W), .SLICE_W(SLICE_W)
  ) u_slice (
    .sample(rd_data),
    .offset(bit_offset),
    .win   (win)
  );

  wv_pixel #(
    .SLICE_W(SLICE_W), .PLOT_W(PLOT_W), .PLOT_LEFT(PLOT_LEFT),
    .PLOT_TOP(PLOT_TOP), .HW(HW), .VW(VW)
  ) u_pixel (
    .clk    (clk),
    .rst_n  (rst_n),
    .hcnt   (hcnt),
    .vcnt   (vcnt),
    .tim_in (tim_raw),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .win    (win),
    .tim_out(tim_out),
    .pix_out(pix_code)
  );

  assign hsync = tim_out.hsync;
  assign vsync = tim_out.vsync;
  assign de    = tim_out.de;
  assign pix   = pix_code;

  // R9: no sync, video or reads while reset is held
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !(hsync || vsync || de || (pix != 2'b00)));

endmodule

// File: tb/wave_trace_viewer_bench.sv
module wave_trace_viewer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_W  = 12;
  localparam int SLICE_W   = 3;
  localparam int PLOT_W    = 10;
  localparam int PLOT_LEFT = 2;
  localparam int PLOT_TOP  = 1;
  localparam int H_ACT = 14, H_FP = 2, H_SYNC = 3, H_BP = 2;
  localparam int V_ACT = 11, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int OFS_W   = $clog2(SAMPLE_W);
  localparam int ADDR_W  = $clog2(PLOT_W);
  localparam int PLOT_H  = 2 ** SLICE_W;
  localparam int HALF    = PLOT_H / 2;
  localparam int NFRAMES = 30;
  localparam int WD_CYCLES = 40000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [OFS_W-1:0]    bit_offset = '0;
  logic                rd_en;
  logic [ADDR_W-1:0]   rd_addr;
  logic [SAMPLE_W-1:0] rd_data = '0;
  logic                hsync, vsync, de;
  logic [1:0]          pix;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wave_trace_viewer #(
    .SAMPLE_W(SAMPLE_W), .SLICE_W(SLICE_W), .PLOT_W(PLOT_W),
    .PLOT_LEFT(PLOT_LEFT), .PLOT_TOP(PLOT_TOP),
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_wave_trace_viewer (
    .clk(clk), .rst_n(rst_n), .bit_offset(bit_offset),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix(pix)
  );

  // sample buffer with one clock of read latency
  logic [SAMPLE_W-1:0] mem [PLOT_W];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int checks = 0;
  int failures = 0;
  int mh = 0, mv = 0, frame = 0, off_now = 0;
  bit done = 1'b0;
  int q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at frame %0d", tag, what, act, exp, frame);
    end
  endtask

  function automatic int pattern(int k, int x);
    case (k % 6)
      0: return x * 301 - 1500;
      1: return 0;
      2: return -1;
      3: return ((x + 1) * 40503) ^ (k * 977);
      4: return k * 13 + 7;
      default: return (x % 2 == 1) ? 2047 : -2048;
    endcase
  endfunction

  task automatic load_frame(int k);
    off_now = (k * 5) % 16;
    bit_offset = OFS_W'(off_now);
    for (int x = 0; x < PLOT_W; x++) mem[x] = SAMPLE_W'(pattern(k, x));
  endtask

  // expected word: region<<8 | de<<4 | hsync<<3 | vsync<<2 | pix
  function automatic int expect_at(int h, int v);
    int e_de, e_hs, e_vs, e_pix, region, x, y, sv, w;
    e_de = (h < H_ACT && v < V_ACT) ? 1 : 0;
    e_hs = (h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SYNC) ? 1 : 0;
    e_vs = (v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SYNC) ? 1 : 0;
    e_pix = 0;
    if (e_de == 0) region = 0;
    else if (!(h >= PLOT_LEFT && h < PLOT_LEFT + PLOT_W &&
               v >= PLOT_TOP && v < PLOT_TOP + PLOT_H)) region = 1;
    else begin
      x = h - PLOT_LEFT;
      y = v - PLOT_TOP;
      sv = int'($signed(mem[x]));
      w = (sv >>> off_now) & (PLOT_H - 1);
      if (w >= HALF) w -= PLOT_H;
      if (y == HALF - 1 - w)  e_pix = 2;
      else if (y == HALF - 1) e_pix = 1;
      region = (y == HALF - 1) ? 2 : 3;
    end
    return (region << 8) | (e_de << 4) | (e_hs << 3) | (e_vs << 2) | e_pix;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      // R9: quiet outputs while reset is held
      check(!hsync && !vsync && !de && pix == 2'b00 && !rd_en, "R9", "reset outputs",
            {hsync, vsync, de, pix, rd_en}, 0);
    end else if (!done) begin
      int e, region;
      bit e_rd;
      string ptag;
      e = q.pop_front();
      region = e >> 8;
      check(hsync == e[3], "R1/R10", "hsync", hsync, e[3]);
      check(vsync == e[2], "R2/R10", "vsync", vsync, e[2]);
      check(de == e[4], "R3/R10", "de", de, e[4]);
      case (region)
        0: ptag = "R3";
        1: ptag = "R8";
        2: ptag = "R7";
        default: ptag = "R5/R6";
      endcase
      check(int'(pix) == (e & 3), ptag, "pix", pix, e & 3);
      // R4: read strobe and address follow the counters in the same cycle
      e_rd = (mh >= PLOT_LEFT && mh < PLOT_LEFT + PLOT_W &&
              mv >= PLOT_TOP && mv < PLOT_TOP + PLOT_H);
      check(rd_en == e_rd, "R4", "rd_en", rd_en, e_rd);
      if (e_rd) check(int'(rd_addr) == mh - PLOT_LEFT, "R4", "rd_addr", rd_addr, mh - PLOT_LEFT);
      q.push_back(expect_at(mh, mv));
      mh++;
      if (mh == H_TOTAL) begin
        mh = 0;
        mv = (mv == V_TOTAL - 1) ? 0 : mv + 1;
      end
      if (mh == 0 && mv == V_ACT) begin
        frame++;
        if (frame == NFRAMES) done = 1'b1;
        else load_frame(frame);
      end
    end
  end

  initial begin
    load_frame(0);
    q.push_back(0);
    q.push_back(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int c = 0; c < WD_CYCLES && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog frames actual=%0d expected=%0d", frame, NFRAMES);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule